// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits between the host write path and the page programming controller of a byte-wide nonvolatile memory. Every completed host write reaches it as a one-cycle event carrying an address and a data byte. It compares these events against two fixed command sequences. A three-write unlock sequence switches on a persistent protection flag and opens a single page-load window. A six-write disable sequence switches the flag off once the next programming cycle reports completion. For each write event it decides whether the write may be committed to the array. It drives that decision to the page controller as a one-cycle permit pulse.

The protection flag survives a soft reset and is cleared only by a power-on reset, which models the unprotected shipped state. When the flag is clear, ordinary writes pass straight through. The matcher still watches for the command sequences. When the flag is set, writes are discarded unless a page-load window is open. A discarded write never produces a permit pulse, so no programming cycle and no data polling follow it. The window closes when the programming-done pulse arrives, and the part falls back to protected.

Top module: `wp_seq_guard`

## Requirements
- R1: The writes 0xAA to key 0x5555, then 0x55 to key 0x2AAA, then 0xA0 to key 0x5555 set `prot_on` and `load_open` one cycle after the third event, whatever the flag was before.
- R2: Only address bits [14:0] form the key; bits 16 and 15 have no effect on sequence matching.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 arm a pending disable. `prot_on` stays set until the next `prog_done` pulse and then clears.
- R4: While `prot_on` is set and `load_open` is clear, no write event produces a `wr_commit` pulse.
- R5: While `load_open` is set, every write other than a sequence-completing write produces `wr_commit`. A `prog_done` pulse closes the window and leaves `prot_on` set.
- R6: A write that does not match the next expected step returns the matcher to idle. That write is not itself taken as the first step of a new sequence.
- R7: `wr_commit` pulses exactly one cycle after an accepted write. With `prot_on` clear, every write is accepted except the one that completes a sequence, which is never committed.
- R8: A power-on reset (`por_n` low) clears every output and the flag. A soft reset (`rst_n` low) clears the matcher, the window, the pending disable and `wr_commit`, but keeps `prot_on`.
- R9: A write event and `prog_done` may arrive in the same cycle. A sequence completion in that cycle takes effect after the `prog_done` effect, so an unlock still leaves `load_open` set. A window write in that cycle still commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset, clears the persistent flag |
| rst_n | input | 1 | Synchronous active-low soft reset, keeps the flag |
| wr_evt | input | 1 | One-cycle pulse marking a completed host write |
| wr_addr | input | 17 | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| prog_done | input | 1 | One-cycle pulse from the page controller at the end of programming |
| wr_commit | output | 1 | Write permit, one cycle after an accepted write |
| prot_on | output | 1 | Persistent protection flag |
| load_open | output | 1 | Page-load window open after an unlock |

## Verification
The delicate overlap is the arrival of `prog_done` in the same cycle as a write event. That write may finish an unlock, finish a disable, or be a page-load write inside the open window. Directed cases place the final unlock write and a window write exactly on the `prog_done` cycle. The random phase injects `prog_done` at a high rate into traffic heavy with command steps, so these collisions recur many times. The outcome of every cycle is judged against a bench model of R1 to R9 that applies the programming-done effect first and the write effect after it.

// File: rtl/wp_pkg.sv
// Shared constants and types for the write-protection sequencer.
// Assumes command keys are the low KEY_W address bits.
package wp_pkg;
    localparam int KEY_W  = 15;
    localparam int DATA_W = 8;

    localparam logic [KEY_W-1:0]  KEY_HI = 15'h5555;
    localparam logic [KEY_W-1:0]  KEY_LO = 15'h2AAA;

    localparam logic [DATA_W-1:0] BYTE_OPEN1 = 8'hAA;
    localparam logic [DATA_W-1:0] BYTE_OPEN2 = 8'h55;
    localparam logic [DATA_W-1:0] BYTE_LOCK  = 8'hA0;
    localparam logic [DATA_W-1:0] BYTE_ESC   = 8'h80;
    localparam logic [DATA_W-1:0] BYTE_FREE  = 8'h20;

    // Progress through the shared prefix and the disable tail.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_P1    = 3'd1,
        ST_P2    = 3'd2,
        ST_ESC   = 3'd3,
        ST_T1    = 3'd4,
        ST_T2    = 3'd5
    } step_t;
endpackage

// File: rtl/wp_key_match.sv
// Command matcher: follows write events through the unlock and disable
// sequences and flags the event that completes one of them.
// Assumes wr_evt is a single-cycle strobe; any off-sequence write aborts.
module wp_key_match
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [KEY_W-1:0]  key,
    input  logic [DATA_W-1:0] data,
    output logic              unlock_hit,
    output logic              disable_hit
);
    step_t step_q, step_nxt;
    logic  at_hi, at_lo, ul_c, dl_c;

    assign at_hi = (key == KEY_HI);
    assign at_lo = (key == KEY_LO);

    // Next-step decode for the current write.
    always_comb begin
        step_nxt = ST_IDLE;
        ul_c     = 1'b0;
        dl_c     = 1'b0;
        case (step_q)
            ST_IDLE: if (at_hi && data == BYTE_OPEN1) step_nxt = ST_P1;
            ST_P1:   if (at_lo && data == BYTE_OPEN2) step_nxt = ST_P2;
            ST_P2: begin
                if (at_hi && data == BYTE_LOCK)     ul_c = 1'b1;
                else if (at_hi && data == BYTE_ESC) step_nxt = ST_ESC;
            end
            ST_ESC:  if (at_hi && data == BYTE_OPEN1) step_nxt = ST_T1;
            ST_T1:   if (at_lo && data == BYTE_OPEN2) step_nxt = ST_T2;
            ST_T2:   if (at_hi && data == BYTE_FREE)  dl_c = 1'b1;
            default: step_nxt = ST_IDLE;
        endcase
    end

    assign unlock_hit  = wr_evt && ul_c;
    assign disable_hit = wr_evt && dl_c;

    // Step register, advanced only on write events.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) step_q <= ST_IDLE;
        else if (wr_evt)      step_q <= step_nxt;
    end

    // R6: a write to neither key always drops progress.
    a_r6_stray_aborts: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (wr_evt && !at_hi && !at_lo) |=> (step_q == ST_IDLE));

    // R3: the tail of the disable sequence is reached only through the escape step.
    a_r3_tail_order: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (step_q == ST_T1) |-> ($past(step_q) == ST_ESC || $past(step_q) == ST_T1));
endmodule

// File: rtl/wp_mode_ctl.sv
// Protection state: persistent flag, single page-load window, pending
// disable and the per-write commit permit.
// Assumes prog_done pulses once per programming cycle; a sequence hit in
// the same cycle is applied after the prog_done effect.
module wp_mode_ctl (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic wr_evt,
    input  logic unlock_hit,
    input  logic disable_hit,
    input  logic prog_done,
    output logic prot_q,
    output logic win_q,
    output logic commit_q
);
    logic pend_q;
    logic accept;

    assign accept = wr_evt && !unlock_hit && !disable_hit && (!prot_q || win_q);

    // Persistent flag: cleared by power-on only, or by a finished disable.
    always_ff @(posedge clk) begin
        if (!por_n)                    prot_q <= 1'b0;
        else if (!rst_n)               prot_q <= prot_q;
        else if (unlock_hit)           prot_q <= 1'b1;
        else if (prog_done && pend_q)  prot_q <= 1'b0;
    end

    // Page-load window and pending disable, volatile state.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            win_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (unlock_hit) begin
            win_q  <= 1'b1;
            pend_q <= 1'b0;
        end else if (disable_hit) begin
            win_q  <= 1'b0;
            pend_q <= 1'b1;
        end else if (prog_done) begin
            win_q  <= 1'b0;
            pend_q <= 1'b0;
        end
    end

    // One-cycle permit to the page controller.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) commit_q <= 1'b0;
        else                  commit_q <= accept;
    end

    // R4: a locked part never forwards a write.
    a_r4_locked_blocks: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (wr_evt && prot_q && !win_q) |=> !commit_q);

    // R7: the write finishing a sequence is never committed.
    a_r7_hit_not_committed: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (unlock_hit || disable_hit) |=> !commit_q);

    // R3: a pending disable clears the flag at programming done.
    a_r3_done_clears: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (prog_done && pend_q && !unlock_hit) |=> !prot_q);

    // R8: a soft reset leaves the flag untouched.
    a_r8_flag_survives: assert property (@(posedge clk)
        disable iff (!por_n)
        (!rst_n) |=> (prot_q == $past(prot_q)));

    // R5: the window and a pending disable never coexist.
    a_r5_window_excl: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        !(win_q && pend_q));
endmodule

// File: rtl/wp_seq_guard.sv
// Top of the write-protection sequencer: keys the address, runs the
// command matcher and the protection state, and issues the write permit.
// Assumes one write event per cycle at most and a synchronous host side.
module wp_seq_guard #(
    parameter int ADDR_W = 17
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       rst_n,
    input  logic                       wr_evt,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [wp_pkg::DATA_W-1:0]  wr_data,
    input  logic                       prog_done,
    output logic                       wr_commit,
    output logic                       prot_on,
    output logic                       load_open
);
    import wp_pkg::*;

    logic [KEY_W-1:0] key;
    logic             unlock_hit, disable_hit;

    // Key extraction: upper address bits take no part in matching.
    generate
        if (ADDR_W > KEY_W) begin : g_trim
            assign key = wr_addr[KEY_W-1:0];

            // R2: an unlock with upper bits set still opens the window.
            a_r2_upper_ignored: assert property (@(posedge clk)
                disable iff (!por_n || !rst_n)
                (unlock_hit && wr_addr[ADDR_W-1:KEY_W] != '0) |=> load_open);
        end else begin : g_pad
            assign key = KEY_W'(wr_addr);
        end
    endgenerate

    wp_key_match u_match (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_evt      (wr_evt),
        .key         (key),
        .data        (wr_data),
        .unlock_hit  (unlock_hit),
        .disable_hit (disable_hit)
    );

    wp_mode_ctl u_mode (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .wr_evt      (wr_evt),
        .unlock_hit  (unlock_hit),
        .disable_hit (disable_hit),
        .prog_done   (prog_done),
        .prot_q      (prot_on),
        .win_q       (load_open),
        .commit_q    (wr_commit)
    );

    // R1: a completed unlock yields protected state with the window open.
    a_r1_unlock_opens: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        unlock_hit |=> (prot_on && load_open));

    // R9: a window write landing on prog_done still commits.
    a_r9_window_done_commit: assert property (@(posedge clk)
        disable iff (!por_n || !rst_n)
        (wr_evt && load_open && prog_done && !unlock_hit && !disable_hit) |=> (wr_commit && !load_open));
endmodule

// File: tb/wp_seq_guard_bench.sv
module wp_seq_guard_bench;
    logic        clk = 1'b0;
    logic        por_n, rst_n, wr_evt, prog_done;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit, prot_on, load_open;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Model state
    int   m_step;
    bit   m_prot, m_win, m_pend, m_commit;
    string cur_tag = "R8";

    always #4 clk = ~clk;

    wp_seq_guard u_wp_seq_guard (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_evt(wr_evt),
        .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
        .wr_commit(wr_commit), .prot_on(prot_on), .load_open(load_open)
    );

    function automatic logic [14:0] step_key(int s);
        return (s == 1 || s == 4) ? 15'h2AAA : 15'h5555;
    endfunction

    function automatic logic [7:0] step_byte(int s);
        case (s)
            0: return 8'hAA; 1: return 8'h55; 2: return 8'h80;
            3: return 8'hAA; 4: return 8'h55; default: return 8'h20;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Requirement model, one step per cycle.
    task automatic model_step(bit ev, logic [16:0] a, logic [7:0] d, bit pd, bit rs, bit po);
        bit ul, dl, adv;
        logic [14:0] k;
        k = a[14:0];
        if (!po) begin
            m_step = 0; m_prot = 0; m_win = 0; m_pend = 0; m_commit = 0;
        end else if (!rs) begin
            m_step = 0; m_win = 0; m_pend = 0; m_commit = 0;
        end else begin
            ul  = ev && m_step == 2 && k == 15'h5555 && d == 8'hA0;
            dl  = ev && m_step == 5 && k == 15'h5555 && d == 8'h20;
            adv = ev && k == step_key(m_step) && d == step_byte(m_step);
            m_commit = ev && !ul && !dl && (!m_prot || m_win);
            if (pd) begin
                if (m_pend) m_prot = 0;
                m_win = 0; m_pend = 0;
            end
            if (ul) begin m_prot = 1; m_win = 1; m_pend = 0; end
            if (dl) begin m_win = 0; m_pend = 1; end
            if (ev) m_step = (ul || dl || !adv) ? 0 : m_step + 1;
        end
    endtask

    task automatic compare_all();
        chk(cur_tag, wr_commit, m_commit, "wr_commit");
        chk(cur_tag, prot_on,   m_prot,   "prot_on");
        chk(cur_tag, load_open, m_win,    "load_open");
    endtask

    // Drive at negedge, then compare at the next negedge.
    task automatic tick(bit ev, logic [16:0] a, logic [7:0] d, bit pd, bit rs, bit po);
        wr_evt = ev; wr_addr = a; wr_data = d; prog_done = pd; rst_n = rs; por_n = po;
        model_step(ev, a, d, pd, rs, po);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d);  tick(1, a, d, 0, 1, 1); endtask
    task automatic wrd(logic [16:0] a, logic [7:0] d); tick(1, a, d, 1, 1, 1); endtask
    task automatic idle();  tick(0, 17'h0, 8'h0, 0, 1, 1); endtask
    task automatic pdone(); tick(0, 17'h0, 8'h0, 1, 1, 1); endtask

    task automatic unlock(logic [16:0] hi);
        wr(hi | 17'h05555, 8'hAA);
        wr(hi | 17'h02AAA, 8'h55);
        wr(hi | 17'h05555, 8'hA0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        // R8: power-on reset state
        cur_tag = "R8";
        tick(0, 0, 0, 0, 1, 0);
        tick(0, 0, 0, 0, 1, 0);
        chk("R8", prot_on, 1'b0, "por prot_on");
        chk("R8", wr_commit, 1'b0, "por wr_commit");
        idle();

        // R7: unprotected writes pass through
        cur_tag = "R7";
        wr(17'h00123, 8'h3C);
        chk("R7", wr_commit, 1'b1, "unprotected commit");
        idle();

        // R1 / R2: unlock with upper address bits set; final write not committed
        cur_tag = "R2";
        unlock(17'h18000);
        chk("R1", prot_on, 1'b1, "unlock prot_on");
        chk("R2", load_open, 1'b1, "upper bits ignored");
        chk("R7", wr_commit, 1'b0, "completing write");

        // R5: window writes commit, prog_done closes the window
        cur_tag = "R5";
        wr(17'h00200, 8'h11);
        chk("R5", wr_commit, 1'b1, "window write");
        wr(17'h00201, 8'h12);
        pdone();
        chk("R5", load_open, 1'b0, "window closed");
        chk("R5", prot_on, 1'b1, "still protected");

        // R4: protected write blocked
        cur_tag = "R4";
        wr(17'h00300, 8'h99);
        chk("R4", wr_commit, 1'b0, "blocked write");

        // R6: mismatch aborts, stray write not a new first step
        cur_tag = "R6";
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h01234, 8'h12); wr(17'h05555, 8'hA0);
        chk("R6", load_open, 1'b0, "aborted unlock");
        wr(17'h05555, 8'hAA); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        chk("R6", load_open, 1'b0, "repeat first step aborts");

        // R9: unlock completes on prog_done, then window write on prog_done
        cur_tag = "R9";
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wrd(17'h05555, 8'hA0);
        chk("R9", load_open, 1'b1, "unlock beats prog_done");
        wrd(17'h00400, 8'h44);
        chk("R9", wr_commit, 1'b1, "window write on done");
        chk("R9", load_open, 1'b0, "window closed on done");

        // R8: soft reset keeps flag, clears window
        cur_tag = "R8";
        unlock(17'h0);
        tick(0, 0, 0, 0, 0, 1);
        chk("R8", prot_on, 1'b1, "soft reset keeps flag");
        chk("R8", load_open, 1'b0, "soft reset clears window");
        idle();

        // R3: disable waits for prog_done
        cur_tag = "R3";
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h20);
        chk("R3", prot_on, 1'b1, "pending disable");
        idle();
        pdone();
        chk("R3", prot_on, 1'b0, "disabled after done");
        wr(17'h00500, 8'h55);
        chk("R3", wr_commit, 1'b1, "write after disable");

        // R8: power-on clears a set flag
        unlock(17'h0);
        tick(0, 0, 0, 0, 1, 0);
        chk("R8", prot_on, 1'b0, "por clears flag");
        idle();

        // Random phase biased toward command steps and prog_done collisions
        cur_tag = "R9";
        for (int i = 0; i < 4000; i++) begin
            int sel;
            bit ev, pd, rs, po;
            logic [16:0] a;
            logic [7:0] d;
            sel = int'($urandom_range(0, 9));
            ev  = ($urandom_range(0, 3) != 0);
            pd  = ($urandom_range(0, 5) == 0);
            rs  = ($urandom_range(0, 99) != 0);
            po  = ($urandom_range(0, 299) != 0);
            a   = {$urandom_range(0, 3), 15'h0};
            if (sel < 6) begin
                a[14:0] = step_key(sel);
                d = step_byte(sel);
            end else if (sel < 8) begin
                a[14:0] = 15'h5555;
                d = 8'hA0;
            end else begin
                a[14:0] = 15'($urandom);
                d = 8'($urandom);
            end
            tick(ev, a, d, pd, rs, po);
        end

        done_flag = 1;
        finish_run();
    end
endmodule